// File: doc/BRIEF.md
# Multi-Slope Run-Down Sequencer

This block controls the run-down phase of an integrating converter that removes the leftover integrator charge with a set of reference slopes, each one a tenth as steep as the slope before it. The steepest slope runs first. It drains most of the residual charge and overshoots zero. Each gentler slope then drives the integrator back the other way until the comparator flips again, and so resolves one more decimal digit. The whole run-down takes a few tens of clocks, where a single slope would need thousands.

A conversion is requested with a start pulse and the sign of the residual charge. The block drives one slope-enable line at a time and a direction line, and it counts the clocks of each slope. When the last slope ends, it forms a signed result by weighting each count with its slope's rate, alternating the sign with the direction. A slope that fails to reach zero within its clock budget aborts the conversion with an error.

Top module: `rundown_seq`

## Requirements
- R1: After reset all slope enables, `done`, `error` and `busy` are low and `result` is zero.
- R2: A start pulse taken while idle enables the steepest slope (`slope_en` bit 0) on the next cycle, with `slope_dir` equal to `start_pol`. `slope_dir` = 1 drives the integrator downward and `cmp` = 1 means the integrator is above zero.
- R3: At most one `slope_en` bit is high in any cycle, and exactly one cycle with all enables low separates two consecutive slopes.
- R4: A slope ends in the first enabled cycle in which `cmp` differs from `slope_dir`. Its count is the number of cycles for which it was enabled, including that cycle.
- R5: Slopes are enabled in the order bit 0, 1, 2, 3, and each slope runs in the direction opposite to the slope before it.
- R6: If a slope is still enabled without a crossing after its limit of cycles (20 for the first slope, BASE+MARGIN = 12 for the later ones), the block removes every enable on the next cycle, pulses `done` and `error` together for one cycle and sets `result` to zero.
- R7: A crossing seen in the cycle in which a slope reaches exactly its limit ends that slope normally, with no error.
- R8: One all-low cycle after the last slope ends, `done` pulses for one cycle with `error` low. In that cycle `result` = c1·1000 − c2·100 + c3·10 − c4, negated when `start_pol` was 0. The value holds until the next accepted start, which clears it to zero.
- R9: A start pulse arriving while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request |
| start_pol | input | 1 | Sign of the residual charge (1 = positive) |
| cmp | input | 1 | Comparator, 1 while the integrator is above zero |
| slope_en | output | NUM_SLOPES | One-hot slope select, bit 0 steepest |
| slope_dir | output | 1 | 1 = drive integrator down, 0 = up |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Abort flag, valid with `done` |
| result | output | RES_W | Signed weighted sum of the slope counts |

## Verification
Two events can fall in the same cycle: the comparator crossing and a slope's count reaching its limit. The bench loads its integrator model with a charge that reaches exactly zero on the last allowed cycle of the first slope, and expects a normal finish with no error. It then adds one unit of charge and expects an abort. It also raises a start pulse of the opposite polarity in the middle of a conversion. The per-clock reference model must see that pulse leave the enables, the direction and the final value unchanged.

// File: rtl/rundown_pkg.sv
package rundown_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RUN,
        PH_GAP,
        PH_SUM
    } phase_t;

    // Rate of slope k relative to the gentlest one: base^(n-1-k)
    function automatic int slope_weight(int base, int nslopes, int k);
        int w;
        w = 1;
        for (int i = 0; i < nslopes - 1 - k; i++) begin
            w = w * base;
        end
        return w;
    endfunction

endpackage

// File: rtl/rs_slope_ctrl.sv
module rs_slope_ctrl
    import rundown_pkg::*;
#(
    parameter int NUM_SLOPES  = 4,
    parameter int CNT_W       = 5,
    parameter int FIRST_LIMIT = 20,
    parameter int LATER_LIMIT = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          start_pol,
    input  logic                          cmp,
    output logic [NUM_SLOPES-1:0]         slope_en,
    output logic                          slope_dir,
    output logic                          busy,
    output logic                          accept,
    output logic                          cap_valid,
    output logic [$clog2(NUM_SLOPES)-1:0] cap_idx,
    output logic [CNT_W-1:0]              cap_cnt,
    output logic                          sum_go,
    output logic                          abort
);
    localparam int IDX_W = $clog2(NUM_SLOPES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOPES - 1);
    localparam logic [CNT_W-1:0] LIM_FIRST = CNT_W'(FIRST_LIMIT);
    localparam logic [CNT_W-1:0] LIM_LATER = CNT_W'(LATER_LIMIT);

    phase_t           ph_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic [CNT_W-1:0] lim;
    logic             crossed;

    assign lim     = (idx_q == '0) ? LIM_FIRST : LIM_LATER;
    assign crossed = (cmp != dir_q);

    assign accept    = (ph_q == PH_IDLE) && start;
    assign cap_valid = (ph_q == PH_RUN) && crossed;
    assign abort     = (ph_q == PH_RUN) && !crossed && (cnt_q == lim - 1'b1);
    assign sum_go    = (ph_q == PH_SUM);
    assign cap_idx   = idx_q;
    assign cap_cnt   = cnt_q + 1'b1;
    assign busy      = (ph_q != PH_IDLE);
    assign slope_dir = dir_q;

    for (genvar k = 0; k < NUM_SLOPES; k++) begin : g_en
        assign slope_en[k] = (ph_q == PH_RUN) && (idx_q == IDX_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            idx_q <= '0;
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q  <= PH_RUN;
                        idx_q <= '0;
                        cnt_q <= '0;
                        dir_q <= start_pol;
                    end
                end
                PH_RUN: begin
                    if (crossed) begin
                        ph_q <= (idx_q == LAST_IDX) ? PH_SUM : PH_GAP;
                    end else if (abort) begin
                        ph_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_GAP: begin
                    ph_q  <= PH_RUN;
                    idx_q <= idx_q + 1'b1;
                    cnt_q <= '0;
                    dir_q <= ~dir_q;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rs_count_store.sv
module rs_count_store #(
    parameter int NUM_SLOPES = 4,
    parameter int CNT_W      = 5
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                clear,
    input  logic                                cap_valid,
    input  logic [$clog2(NUM_SLOPES)-1:0]       cap_idx,
    input  logic [CNT_W-1:0]                    cap_cnt,
    output logic [NUM_SLOPES-1:0][CNT_W-1:0]    counts
);
    localparam int IDX_W = $clog2(NUM_SLOPES);

    for (genvar k = 0; k < NUM_SLOPES; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                counts[k] <= '0;
            end else if (cap_valid && cap_idx == IDX_W'(k)) begin
                counts[k] <= cap_cnt;
            end
        end
    end

endmodule

// File: rtl/rs_combine.sv
module rs_combine
    import rundown_pkg::*;
#(
    parameter int NUM_SLOPES = 4,
    parameter int BASE       = 10,
    parameter int CNT_W      = 5,
    parameter int RES_W      = 24
) (
    input  logic [NUM_SLOPES-1:0][CNT_W-1:0] counts,
    output logic signed [RES_W-1:0]          sum
);
    logic signed [RES_W-1:0] term [NUM_SLOPES];

    for (genvar k = 0; k < NUM_SLOPES; k++) begin : g_term
        localparam int W_K = slope_weight(BASE, NUM_SLOPES, k);
        assign term[k] = $signed({{(RES_W-CNT_W){1'b0}}, counts[k]})
                       * $signed(RES_W'(W_K));
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < NUM_SLOPES; k++) begin
            if (k % 2 == 0) sum = sum + term[k];
            else            sum = sum - term[k];
        end
    end

endmodule

// File: rtl/rundown_seq.sv
module rundown_seq
    import rundown_pkg::*;
#(
    parameter int NUM_SLOPES  = 4,
    parameter int BASE        = 10,
    parameter int MARGIN      = 2,
    parameter int FIRST_LIMIT = 20,
    parameter int RES_W       = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    start_pol,
    input  logic                    cmp,
    output logic [NUM_SLOPES-1:0]   slope_en,
    output logic                    slope_dir,
    output logic                    busy,
    output logic                    done,
    output logic                    error,
    output logic signed [RES_W-1:0] result
);
    localparam int LATER_LIMIT = BASE + MARGIN;
    localparam int MAX_LIMIT   = (FIRST_LIMIT > LATER_LIMIT) ? FIRST_LIMIT : LATER_LIMIT;
    localparam int CNT_W       = $clog2(MAX_LIMIT + 1);
    localparam int IDX_W       = $clog2(NUM_SLOPES);

    logic                             accept;
    logic                             cap_valid;
    logic [IDX_W-1:0]                 cap_idx;
    logic [CNT_W-1:0]                 cap_cnt;
    logic                             sum_go;
    logic                             abort;
    logic [NUM_SLOPES-1:0][CNT_W-1:0] counts;
    logic signed [RES_W-1:0]          sum;
    logic                             pol_q;

    rs_slope_ctrl #(
        .NUM_SLOPES (NUM_SLOPES),
        .CNT_W      (CNT_W),
        .FIRST_LIMIT(FIRST_LIMIT),
        .LATER_LIMIT(LATER_LIMIT)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .start_pol(start_pol),
        .cmp      (cmp),
        .slope_en (slope_en),
        .slope_dir(slope_dir),
        .busy     (busy),
        .accept   (accept),
        .cap_valid(cap_valid),
        .cap_idx  (cap_idx),
        .cap_cnt  (cap_cnt),
        .sum_go   (sum_go),
        .abort    (abort)
    );

    rs_count_store #(
        .NUM_SLOPES(NUM_SLOPES),
        .CNT_W     (CNT_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .cap_valid(cap_valid),
        .cap_idx  (cap_idx),
        .cap_cnt  (cap_cnt),
        .counts   (counts)
    );

    rs_combine #(
        .NUM_SLOPES(NUM_SLOPES),
        .BASE      (BASE),
        .CNT_W     (CNT_W),
        .RES_W     (RES_W)
    ) u_comb (
        .counts(counts),
        .sum   (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= 1'b0;
            result <= '0;
            done   <= 1'b0;
            error  <= 1'b0;
        end else begin
            done  <= sum_go | abort;
            error <= abort;
            if (accept) begin
                pol_q  <= start_pol;
                result <= '0;
            end else if (abort) begin
                result <= '0;
            end else if (sum_go) begin
                result <= pol_q ? sum : -sum;
            end
        end
    end

endmodule

// File: rtl/rundown_seq_chk.sv
module rundown_seq_chk #(
    parameter int NUM_SLOPES = 4,
    parameter int RES_W      = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    start_pol,
    input logic [NUM_SLOPES-1:0]   slope_en,
    input logic                    slope_dir,
    input logic                    busy,
    input logic                    done,
    input logic                    error,
    input logic signed [RES_W-1:0] result
);
    p_onehot_en_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slope_en));

    p_switch_via_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (slope_en != '0) && ($past(slope_en) != '0) |-> slope_en == $past(slope_en));

    p_start_first_r2: assert property (@(posedge clk) disable iff (rst)
        !busy && start |=> (slope_en == NUM_SLOPES'(1)) && (slope_dir == $past(start_pol)));

    p_dir_flip_r5: assert property (@(posedge clk) disable iff (rst)
        (slope_en != '0) && ($past(slope_en) == '0) && ($past(slope_en, 2) != '0)
        |-> slope_dir != $past(slope_dir, 2));

    p_error_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && (slope_en == '0));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(result));

    p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (rst)
        busy && start && (slope_en != '0) |=> (slope_en == $past(slope_en)) || (slope_en == '0));
endmodule

bind rundown_seq rundown_seq_chk #(
    .NUM_SLOPES(NUM_SLOPES),
    .RES_W     (RES_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .start_pol(start_pol),
    .slope_en (slope_en),
    .slope_dir(slope_dir),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .result   (result)
);

// File: tb/rundown_seq_bench.sv
`timescale 1ns/1ps
module rundown_seq_bench;
    localparam int NS   = 4;
    localparam int RW   = 24;
    localparam int LIM0 = 20;
    localparam int LIMN = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          start_pol = 1'b0;
    logic          cmp = 1'b0;
    logic [NS-1:0] slope_en;
    logic          slope_dir;
    logic          busy;
    logic          done;
    logic          error;
    logic signed [RW-1:0] result;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 0;

    // integrator stand-in
    longint q = 0;
    bit     man = 0;
    bit     cmp_m = 0;

    // reference model state
    int  m_ph = 0;   // 0 idle 1 run 2 gap 3 sum
    int  m_idx = 0, m_cnt = 0, m_dir = 0, m_pol = 0;
    int  m_counts [NS];
    int  m_done = 0, m_err = 0, m_res = 0;

    always #10 clk = ~clk;

    rundown_seq u_rundown_seq (
        .clk(clk), .rst(rst), .start(start), .start_pol(start_pol), .cmp(cmp),
        .slope_en(slope_en), .slope_dir(slope_dir), .busy(busy),
        .done(done), .error(error), .result(result)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference, one step per clock
    always @(posedge clk) begin
        int lim, r, w;
        m_done = 0;
        m_err  = 0;
        if (rst) begin
            m_ph = 0; m_idx = 0; m_cnt = 0; m_dir = 0; m_pol = 0; m_res = 0;
        end else begin
            case (m_ph)
                0: if (start) begin
                    m_ph = 1; m_idx = 0; m_cnt = 0; m_dir = start_pol; m_pol = start_pol; m_res = 0;
                end
                1: begin
                    lim = (m_idx == 0) ? LIM0 : LIMN;
                    if (int'(cmp) != m_dir) begin
                        m_counts[m_idx] = m_cnt + 1;
                        m_ph = (m_idx == NS - 1) ? 3 : 2;
                    end else if (m_cnt + 1 == lim) begin
                        m_ph = 0; m_done = 1; m_err = 1; m_res = 0;
                    end else begin
                        m_cnt++;
                    end
                end
                2: begin
                    m_ph = 1; m_idx++; m_cnt = 0; m_dir = 1 - m_dir;
                end
                default: begin
                    r = 0; w = 1;
                    for (int k = NS - 1; k >= 0; k--) begin
                        r = (k % 2 == 0) ? r + m_counts[k] * w : r - m_counts[k] * w;
                        w = w * 10;
                    end
                    m_res = m_pol ? r : -r;
                    m_done = 1;
                    m_ph = 0;
                end
            endcase
        end
    end

    // per-clock compare, then integrator step and comparator drive
    always @(negedge clk) begin
        int exp_en;
        int act_res;
        exp_en  = (m_ph == 1) ? (1 << m_idx) : 0;
        act_res = $signed(result);
        check(int'(slope_en) == exp_en, "R3/R5 slope_en", slope_en, exp_en);
        if (m_ph == 1)
            check(int'(slope_dir) == m_dir, "R5 slope_dir", slope_dir, m_dir);
        check(int'(done) == m_done, "R8 done", done, m_done);
        check(int'(error) == m_err, "R6 error", error, m_err);
        check(act_res == m_res, "R8 result", act_res, m_res);
        check(int'(busy) == int'(m_ph != 0), "R9 busy", busy, m_ph != 0);
        for (int k = 0; k < NS; k++) begin
            longint rate;
            rate = 1;
            for (int j = 0; j < NS - 1 - k; j++) rate = rate * 10;
            if (slope_en[k]) q = slope_dir ? q - rate : q + rate;
        end
        cmp = man ? cmp_m : (q > 0);
    end

    task automatic launch(input longint q0, input bit pol);
        @(negedge clk); #2;
        man = 0; q = q0; cmp = (q0 > 0);
        start = 1; start_pol = pol;
        @(negedge clk); #2;
        start = 0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 300 && !seen; i++) begin
            @(negedge clk); #1;
            if (done) seen = 1;
        end
    endtask

    initial begin
        bit seen;
        int hold;
        repeat (3) @(negedge clk);
        #2 rst = 0;
        @(negedge clk); #1;
        // R1
        check(slope_en == '0 && !done && !error && !busy, "R1 reset outputs", {slope_en, done, error, busy}, 0);
        check(result == '0, "R1 reset result", result, 0);

        // R2 + R8 positive charge
        launch(2500, 1'b1);
        #1 check(slope_en == 4'b0001 && slope_dir == 1'b1, "R2 first slope pol1", {slope_en, slope_dir}, 5'b00011);
        wait_done(seen);
        check(seen && !error, "R8 done without error", error, 0);
        check($signed(result) == 2499, "R8 result +2500 charge", $signed(result), 2499);
        hold = $signed(result);
        repeat (5) @(negedge clk);
        #1 check($signed(result) == hold && !done, "R8 result holds, done one cycle", $signed(result), hold);

        // R2 + R8 negative charge, sign inverted
        launch(-2500, 1'b0);
        #1 check(slope_en == 4'b0001 && slope_dir == 1'b0, "R2 first slope pol0", {slope_en, slope_dir}, 5'b00010);
        wait_done(seen);
        check($signed(result) == -2500, "R8 result -2500 charge", $signed(result), -2500);

        // R4 first slope crosses on its first cycle
        launch(500, 1'b1);
        wait_done(seen);
        check($signed(result) == 499, "R4 one-cycle first slope", $signed(result), 499);

        // R7 crossing exactly at the first-slope limit
        launch(20000, 1'b1);
        wait_done(seen);
        check(seen && !error, "R7 crossing at limit no error", error, 0);
        check($signed(result) == 19999, "R7 result at limit", $signed(result), 19999);

        // R6 first slope overruns by one unit
        launch(20001, 1'b1);
        wait_done(seen);
        check(seen && error, "R6 first-slope abort", error, 1);
        check(result == '0 && slope_en == '0, "R6 abort clears", result, 0);

        // R6 later slope never crosses (manual comparator)
        @(negedge clk); #2;
        man = 1; cmp_m = 1; start = 1; start_pol = 1;
        @(negedge clk); #2;
        start = 0;
        repeat (2) @(negedge clk);
        #2 cmp_m = 0;
        wait_done(seen);
        check(seen && error, "R6 later-slope abort", error, 1);
        man = 0;

        // R9 start of opposite polarity while busy
        launch(2500, 1'b1);
        repeat (4) @(negedge clk);
        #2 start = 1; start_pol = 0;
        @(negedge clk); #2 start = 0;
        wait_done(seen);
        check($signed(result) == 2499, "R9 start while busy ignored", $signed(result), 2499);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule